// File: doc/BRIEF.md
# Deferred Invalidation Queue with Read Barrier

This block takes invalidation requests from the coherence snoop side and acknowledges each one combinationally, in the cycle it is presented. It does not apply the invalidation at that point. Each accepted line address goes into an in-order queue. Later, in any cycle where the cache line-state array port is not claimed by a processor access, the oldest queued address is written to the array with the Invalid state, one per cycle.

Until a queued invalidation has been applied, the processor can still read the old, valid state of that line. This is allowed behaviour. A read barrier gives the processor a point after which every invalidation that was already queued at the barrier's start has reached the array. The barrier does this by taking the array port ahead of processor accesses until those entries have drained.

Invalidations that arrive after the barrier has started do not delay its completion.

Top module: `inval_defer_queue`

## Requirements
- R1: After a synchronous active-low reset, q_empty is 1, q_full is 0 and bar_done is 0. With no requests present, inv_ack and arr_en are 0.
- R2: While the queue is not full, inv_ack equals inv_req in the same cycle, and the address is accepted on that clock edge. Accepting an invalidation does not write the array in that cycle.
- R3: The queue holds DEPTH (8) addresses. When it holds 8, q_full is 1 and inv_ack stays 0 even with inv_req high. inv_ack returns once an entry has been drained.
- R4: Draining drives arr_en=1 and arr_we=1, with arr_addr set to the queued address and arr_wstate set to the Invalid code 2'b00. At most one entry drains per cycle.
- R5: Queued invalidations are applied in the order they were acknowledged.
- R6: Outside a barrier, a processor request (cpu_req=1) is granted in the same cycle (cpu_gnt=1) and no entry drains. Its cpu_we, cpu_addr and cpu_wstate appear on the array port.
- R7: While the processor holds the port, a queued line keeps its previous state in the array. It is not written until its entry drains.
- R8: When bar_req rises, the number of entries then queued is captured. From the next cycle, those entries drain one per cycle, even with cpu_req high, and cpu_gnt is 0 while they drain.
- R9: bar_done is a one-cycle pulse. It is asserted one cycle after the last captured entry has been written. For a barrier raised on an empty queue, it is asserted two clock edges after bar_req is first sampled.
- R10: Invalidations accepted after the barrier started are not drained before bar_done. They are left queued, so q_empty can be 0 while bar_done is 1.
- R11: A second invalidation to an address that is already queued is not merged. It is accepted as a separate entry, each entry writes Invalid, and the final state of the line is Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_req | input | 1 | Invalidation request from the snoop side |
| inv_addr | input | AW | Line address to invalidate |
| inv_ack | output | 1 | Same-cycle acknowledge; the request is accepted when inv_ack is 1 |
| cpu_req | input | 1 | Processor request for the line-state array port |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | AW | Processor line address |
| cpu_wstate | input | 2 | Processor write state (00 Invalid, 01 Shared, 10 Exclusive, 11 Modified) |
| cpu_gnt | output | 1 | Processor owns the array port this cycle |
| arr_en | output | 1 | Array port active |
| arr_we | output | 1 | Array port write |
| arr_addr | output | AW | Array port line address |
| arr_wstate | output | 2 | Array port write state |
| bar_req | input | 1 | Read-barrier request, held high until bar_done |
| bar_done | output | 1 | One-cycle barrier completion pulse |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is a barrier drain and a processor request: the bench holds cpu_req high through the whole barrier, so it can judge that cpu_gnt drops exactly while the captured entries drain and returns in the cycle after the last one. The second pair is an enqueue and a drain at the full boundary: the bench keeps inv_req high against a full queue while the processor releases the port. It then expects the acknowledge to stay withheld in the cycle of the first drain and to return in the next cycle, when the queue is one short of full. In both cases the bench judges the result from the array-port writes it observes and from a line-state model it keeps itself.

// File: rtl/invq_pkg.sv
// Package: shared types of the deferred invalidation queue.
// Assumes a two-bit line-state encoding held by the external array.
package invq_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_DRAIN = 2'd1,
        BS_DONE  = 2'd2,
        BS_HOLD  = 2'd3
    } bar_st_e;
endpackage

// File: rtl/invq_fifo.sv
// Module: in-order store of pending line addresses.
// Assumes the writer never pushes while full and the reader never pops
// while empty; any DEPTH of two or more is supported.
module invq_fifo #(
    parameter int AW    = 6,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] occ
);
    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Store the incoming address at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_addr;
    end

    // Advance the pointers with wrap-around and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (rd_en) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    // Present the head entry and the occupancy flags.
    always_comb begin
        rd_addr = mem[rd_ptr];
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        occ     = count;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full)
        else $error("push into a full queue");

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty)
        else $error("pop from an empty queue");

    p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH))
        else $error("occupancy beyond depth");
endmodule

// File: rtl/invq_barrier.sv
// Module: read-barrier sequencer.
// Captures the queue occupancy when the barrier starts, counts those entries
// as they drain, then pulses done. Assumes bar_req is held until done.
module invq_barrier #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bar_req,
    input  logic [CW-1:0] occ,
    input  logic          drain_fire,
    output logic          urgent,
    output logic          bar_done
);
    import invq_pkg::*;

    bar_st_e       state;
    logic [CW-1:0] left;

    // Step the barrier state and the count of captured entries still queued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BS_IDLE;
            left  <= '0;
        end else begin
            unique case (state)
                BS_IDLE: if (bar_req) begin
                    left  <= occ - CW'(drain_fire);
                    state <= BS_DRAIN;
                end
                BS_DRAIN: begin
                    if (left == '0)      state <= BS_DONE;
                    else if (drain_fire) left  <= left - CW'(1);
                end
                BS_DONE:  state <= bar_req ? BS_HOLD : BS_IDLE;
                BS_HOLD:  if (!bar_req) state <= BS_IDLE;
                default:  state <= BS_IDLE;
            endcase
        end
    end

    // Drain priority while captured entries remain; done in the completion state.
    always_comb begin
        urgent   = (state == BS_DRAIN) && (left != '0);
        bar_done = (state == BS_DONE);
    end

    p_capture_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_DRAIN) |-> (left <= occ))
        else $error("captured count exceeds queue occupancy");

    p_urgent_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> drain_fire)
        else $error("barrier pending but nothing drained");

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |=> !bar_done)
        else $error("done longer than one cycle");

    p_done_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bar_done) |-> ($past(left) == '0))
        else $error("done before captured entries drained");
endmodule

// File: rtl/invq_arb.sv
// Module: line-state array port arbiter.
// The processor wins unless a barrier has entries to drain; a drain always
// writes the Invalid state. Purely combinational.
module invq_arb #(
    parameter int AW = 6
) (
    input  logic          fifo_empty,
    input  logic          urgent,
    input  logic [AW-1:0] head_addr,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_wstate,
    output logic          drain_fire,
    output logic          cpu_gnt,
    output logic          arr_en,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [1:0]    arr_wstate
);
    import invq_pkg::*;

    // Pick the port owner and steer its command onto the array.
    always_comb begin
        drain_fire = !fifo_empty && (urgent || !cpu_req);
        cpu_gnt    = cpu_req && !(urgent && !fifo_empty);
        arr_en     = drain_fire || cpu_gnt;
        arr_we     = drain_fire ? 1'b1 : (cpu_gnt && cpu_we);
        arr_addr   = drain_fire ? head_addr : cpu_addr;
        arr_wstate = drain_fire ? LS_INV : cpu_wstate;
    end
endmodule

// File: rtl/inval_defer_queue.sv
// Module: deferred invalidation queue, top level.
// Acknowledges snoop invalidations at once, queues them, and applies them to
// the line-state array when the port is free or a read barrier demands it.
// Assumes the snoop side drops inv_req after an acknowledged cycle and the
// barrier requester holds bar_req until bar_done.
module inval_defer_queue #(
    parameter int AW    = 6,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inv_req,
    input  logic [AW-1:0] inv_addr,
    output logic          inv_ack,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_wstate,
    output logic          cpu_gnt,
    output logic          arr_en,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [1:0]    arr_wstate,
    input  logic          bar_req,
    output logic          bar_done,
    output logic          q_full,
    output logic          q_empty
);
    import invq_pkg::*;

    logic          push;
    logic          drain_fire;
    logic          urgent;
    logic [AW-1:0] head_addr;
    logic [CW-1:0] occ;

    // Acknowledge whenever there is room; acceptance equals acknowledge.
    always_comb begin
        inv_ack = inv_req && !q_full;
        push    = inv_ack;
    end

    invq_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_addr (inv_addr),
        .rd_en   (drain_fire),
        .rd_addr (head_addr),
        .full    (q_full),
        .empty   (q_empty),
        .occ     (occ)
    );

    invq_barrier #(.DEPTH(DEPTH)) u_bar (
        .clk        (clk),
        .rst_n      (rst_n),
        .bar_req    (bar_req),
        .occ        (occ),
        .drain_fire (drain_fire),
        .urgent     (urgent),
        .bar_done   (bar_done)
    );

    invq_arb #(.AW(AW)) u_arb (
        .fifo_empty (q_empty),
        .urgent     (urgent),
        .head_addr  (head_addr),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wstate (cpu_wstate),
        .drain_fire (drain_fire),
        .cpu_gnt    (cpu_gnt),
        .arr_en     (arr_en),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wstate (arr_wstate)
    );

    p_ack_enqueues_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_ack && !drain_fire) |=> !q_empty)
        else $error("acknowledged invalidation not queued");

    p_barrier_beats_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && cpu_req) |-> !cpu_gnt)
        else $error("processor granted during barrier drain");

    p_drain_writes_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_en && !cpu_gnt) |-> (arr_we && arr_wstate == LS_INV))
        else $error("drain did not write Invalid");

    p_full_withholds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !inv_ack)
        else $error("acknowledge while full");
endmodule

// File: tb/sim_inval_defer_queue.sv
module sim_inval_defer_queue;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          inv_req, cpu_req, cpu_we, bar_req;
    logic [AW-1:0] inv_addr, cpu_addr;
    logic [1:0]    cpu_wstate;
    logic          inv_ack, cpu_gnt, arr_en, arr_we, bar_done, q_full, q_empty;
    logic [AW-1:0] arr_addr;
    logic [1:0]    arr_wstate;

    int nchk = 0;
    int nerr = 0;
    logic [1:0] model [64];

    localparam logic [AW-1:0] VEC [6] = '{6'd3, 6'd60, 6'd7, 6'd33, 6'd1, 6'd42};

    always #5 clk = ~clk;

    inval_defer_queue u0 (
        .clk(clk), .rst_n(rst_n), .inv_req(inv_req), .inv_addr(inv_addr),
        .inv_ack(inv_ack), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wstate(cpu_wstate), .cpu_gnt(cpu_gnt),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wstate(arr_wstate), .bar_req(bar_req), .bar_done(bar_done),
        .q_full(q_full), .q_empty(q_empty)
    );

    // Line-state array model: every line starts Modified (3).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) model[i] <= 2'd3;
        end else if (arr_en && arr_we) begin
            model[arr_addr] <= arr_wstate;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    initial begin
        #2_000_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int hits;
        rst_n = 1'b0; inv_req = 0; cpu_req = 0; cpu_we = 0; bar_req = 0;
        inv_addr = '0; cpu_addr = '0; cpu_wstate = 2'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk("R1 q_empty", q_empty, 1);
        chk("R1 q_full", q_full, 0);
        chk("R1 bar_done", bar_done, 0);
        chk("R1 arr_en", arr_en, 0);
        chk("R1 inv_ack", inv_ack, 0);

        // Table walk: queue while the processor holds the port, then drain.
        cpu_req = 1; cpu_we = 0; cpu_addr = 6'd9;
        for (int i = 0; i < 6; i++) begin
            inv_req = 1; inv_addr = VEC[i];
            #1;
            chk("R2 ack same cycle", inv_ack, 1);
            chk("R6 cpu granted", cpu_gnt, 1);
            chk("R6 read no write", arr_we, 0);
            tick();
        end
        inv_req = 0;
        #1;
        chk("R7 stale line kept", model[VEC[0]], 3);
        chk("R7 queue pending", q_empty, 0);
        cpu_req = 0;
        for (int i = 0; i < 6; i++) begin
            #1;
            chk("R4 drain write", arr_en && arr_we, 1);
            chk("R5 order", arr_addr, VEC[i]);
            chk("R4 invalid code", arr_wstate, 0);
            tick();
        end
        #1;
        chk("R4 queue empty", q_empty, 1);
        for (int i = 0; i < 6; i++) chk("R4 line invalid", model[VEC[i]], 0);

        // Processor write passes through on an empty queue.
        cpu_req = 1; cpu_we = 1; cpu_addr = 6'd5; cpu_wstate = 2'd2;
        #1;
        chk("R6 gnt", cpu_gnt, 1);
        chk("R6 addr", arr_addr, 5);
        chk("R6 state", arr_wstate, 2);
        tick();
        cpu_we = 0;
        #1;
        chk("R6 written", model[5], 2);

        // Full queue withholds acknowledge until a drain.
        for (int i = 0; i < 8; i++) begin
            inv_req = 1; inv_addr = 6'(10 + i);
            #1;
            chk("R3 ack while room", inv_ack, 1);
            tick();
        end
        inv_addr = 6'd40;
        #1;
        chk("R3 full flag", q_full, 1);
        chk("R3 ack withheld", inv_ack, 0);
        tick();
        #1;
        chk("R3 still withheld", inv_ack, 0);
        cpu_req = 0;
        #1;
        chk("R3 withheld in drain cycle", inv_ack, 0);
        chk("R5 first drained", arr_addr, 10);
        tick();
        #1;
        chk("R3 ack after drain", inv_ack, 1);
        tick();
        inv_req = 0;
        repeat (10) tick();
        #1;
        chk("R3 late entry applied", model[40], 0);
        chk("R3 last full entry applied", model[17], 0);
        chk("R3 drained empty", q_empty, 1);

        // Barrier with processor busy; a late arrival stays queued.
        cpu_req = 1;
        for (int i = 0; i < 3; i++) begin
            inv_req = 1; inv_addr = 6'(20 + i);
            tick();
        end
        inv_req = 0;
        bar_req = 1;
        #1;
        chk("R8 start cycle cpu keeps port", cpu_gnt, 1);
        tick();
        inv_req = 1; inv_addr = 6'd30;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 cpu blocked", cpu_gnt, 0);
            chk("R8 drain addr", arr_addr, 20 + i);
            chk("R9 not done yet", bar_done, 0);
            tick();
            inv_req = 0;
        end
        #1;
        chk("R8 cpu regains port", cpu_gnt, 1);
        chk("R9 done waits a cycle", bar_done, 0);
        tick();
        #1;
        chk("R9 done", bar_done, 1);
        chk("R10 late entry left", q_empty, 0);
        chk("R8 captured applied", model[22], 0);
        chk("R10 late line stale", model[30], 3);
        bar_req = 0;
        tick();
        #1;
        chk("R9 one-cycle pulse", bar_done, 0);
        cpu_req = 0;
        tick();
        #1;
        chk("R10 late applied later", model[30], 0);

        // Barrier on an empty queue.
        bar_req = 1;
        #1;
        chk("R9 empty first cycle", bar_done, 0);
        tick();
        #1;
        chk("R9 empty second cycle", bar_done, 0);
        tick();
        #1;
        chk("R9 empty done", bar_done, 1);
        bar_req = 0;
        tick();

        // Duplicate invalidations are kept as separate entries.
        cpu_req = 1;
        for (int i = 0; i < 2; i++) begin
            inv_req = 1; inv_addr = 6'd50;
            #1;
            chk("R11 duplicate ack", inv_ack, 1);
            tick();
        end
        inv_req = 0;
        cpu_req = 0;
        hits = 0;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (arr_en && arr_we && arr_addr == 6'd50) hits++;
            tick();
        end
        chk("R11 two writes", hits, 2);
        chk("R11 final invalid", model[50], 0);

        summary();
        $finish;
    end
endmodule